// File: doc/BRIEF.md
# Tick Counter with One-Shot Compare Interrupt

This block keeps a free-running tick count and a single software-armed deadline. Software loads and reads a 64-bit counter word through a simple strobe interface. The upper bit of that word is a disable flag, and the lower 63 bits are the count. A second write strobe arms a deadline. It carries its own disable bit in the upper position and the deadline value in the lower 63 bits.

The count moves forward by one on every cycle in which `tick_en` is high. When an armed deadline is reached, the block sets its own bit in a soft-interrupt status vector and pulses a wakeup request for one cycle. The deadline then disarms, so it fires once only. Software must write the compare word again before the block can fire a second time. Several copies of the block can share one status vector, each with a different `IRQ_BIT`, by OR-ing their outputs.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the count is 0, `cnt_rd_data[63]` reads 1, `softint` is all zeros, `wake` is low, and no deadline is armed.
- R2: A counter write (`cnt_wr`) loads `wr_data[62:0]` as the count and `wr_data[63]` as the disable flag. In any cycle with `tick_en` high and no counter write, the count goes up by one, whatever the flag says. The count wraps from all ones to zero.
- R3: `cnt_rd_data` always shows the live count in bits 62:0 and the disable flag in bit 63.
- R4: A compare write (`cmp_wr`) with `wr_data[63]`=0 and a nonzero `wr_data[62:0]` arms that deadline. The timer fires on the tick that brings the count to the deadline. If the deadline is already at or below the count, it fires on the next tick.
- R5: A deadline fires at most once. Further ticks raise nothing until software writes a new deadline.
- R6: A compare write whose deadline field is zero leaves the timer unarmed and cancels any armed deadline.
- R7: A compare write with `wr_data[63]`=1 leaves the timer unarmed and cancels any armed deadline.
- R8: When the timer fires, `softint[IRQ_BIT]` (bit 2 by default) becomes 1 and `wake` is high for exactly that one cycle. Both change on the clock edge that ends the firing tick.
- R9: If the counter's disable flag is set on the tick where the deadline is reached, the deadline is used up but `softint` and `wake` stay unchanged.
- R10: `softint[IRQ_BIT]` stays at 1 until a cycle with `softint_clr[IRQ_BIT]`=1 and no fire. If a fire and a clear happen in the same cycle, the bit stays at 1. All other `softint` bits read 0 whatever `softint_clr` holds.
- R11: In the same cycle, a counter write takes precedence over a tick. A compare write in a cycle that would otherwise fire suppresses that fire and takes the new deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Tick: advance the count this cycle |
| cnt_wr | input | 1 | Write strobe for the counter word |
| cmp_wr | input | 1 | Write strobe for the compare word |
| wr_data | input | 64 | Write data shared by both strobes (bit 63 is the disable flag) |
| softint_clr | input | IRQ_W | Write-one-to-clear strobe for the status vector |
| cnt_rd_data | output | 64 | Disable flag in bit 63, live count in bits 62:0 |
| softint | output | IRQ_W | Soft-interrupt status vector |
| wake | output | 1 | One-cycle wakeup pulse on a fire |

## Verification
The assertions take it for granted that reset is held low for at least one clock edge before any property is judged. They also assume that `cmp_wr` and `tick_en` are single-cycle-sampled levels with no relation to each other. Because the wake-pulse property expects software to need at least one cycle to re-arm, the stimulus never fires twice on back-to-back edges. Re-arming always takes a compare write in a separate cycle. The stimulus drives every strobe at the falling edge and holds it for one full cycle. It also keeps deadlines well away from the 63-bit wrap point, except in one dedicated wrap vector that has no deadline armed.

// File: rtl/tick_pkg.sv
// Package: shared types for the tick/compare timer.
// Assumes: nothing beyond IEEE 1800-2017.
package tick_pkg;

    // Arming state of the one-shot deadline.
    typedef enum logic {
        DL_IDLE  = 1'b0,
        DL_ARMED = 1'b1
    } dl_state_e;

endpackage

// File: rtl/tick_counter.sv
// Module: tick_counter
// Holds the free-running count and the counter disable flag.
// Assumes: load has priority over tick_en; the flag never stops counting.
module tick_counter #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_dis,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_inc,
    output logic             dis_flag,
    output logic             step
);

    // Value the count takes on a tick; wraps naturally at CNT_W bits.
    assign count_inc = count + CNT_W'(1);

    // A tick only counts when no software load competes with it.
    assign step = tick_en && !load;

    // Count and flag register: reset, software load, or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dis_flag <= 1'b1;
        end else if (load) begin
            count    <= load_val;
            dis_flag <= load_dis;
        end else if (tick_en) begin
            count    <= count_inc;
        end
    end

    // R2: a tick without a load moves the count up by one.
    a_r2_tick_inc : assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load) |=> (count == $past(count) + CNT_W'(1)));

    // R2: without tick or load the count holds.
    a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(count));

    // R2: a load sets the flag to the written bit.
    a_r2_load_flag : assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dis_flag == $past(load_dis)));

endmodule

// File: rtl/tick_deadline.sv
// Module: tick_deadline
// One-shot deadline comparator: arms on a software write, reports a hit
// on the tick that reaches (or has passed) the deadline, then disarms.
// Assumes: count/count_inc/step come from tick_counter of the same width.
module tick_deadline
    import tick_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_wr,
    input  logic [CNT_W-1:0] arm_val,
    input  logic             arm_dis,
    input  logic             step,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_inc,
    output logic             hit
);

    dl_state_e        state;
    logic [CNT_W-1:0] deadline;
    logic             reached;
    logic             arm_ok;

    // Deadline reached by this tick, or already behind the count.
    assign reached = (count >= deadline) || (count_inc == deadline);

    // A write arms only with a nonzero value and a clear disable bit.
    assign arm_ok = (arm_val != '0) && !arm_dis;

    // A hit needs an armed state, a real tick and no competing write.
    assign hit = (state == DL_ARMED) && step && !arm_wr && reached;

    // Arming state and stored deadline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= DL_IDLE;
            deadline <= '0;
        end else if (arm_wr) begin
            deadline <= arm_val;
            state    <= arm_ok ? DL_ARMED : DL_IDLE;
        end else if (hit) begin
            state    <= DL_IDLE;
        end
    end

    // R5: a hit always leaves the deadline disarmed.
    a_r5_one_shot : assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (state == DL_IDLE));

    // R6: a zero deadline write never arms.
    a_r6_zero_unarmed : assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && (arm_val == '0)) |=> (state == DL_IDLE));

    // R7: a disabled deadline write never arms.
    a_r7_dis_unarmed : assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && arm_dis) |=> (state == DL_IDLE));

    // R11: the cycle after a write cannot see the prior deadline fire.
    a_r11_new_deadline : assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (deadline == $past(arm_val)));

endmodule

// File: rtl/tick_softint.sv
// Module: tick_softint
// Soft-interrupt status vector with write-one-to-clear and a wake pulse.
// Only bit IRQ_BIT can ever be set; a fire outranks a clear.
// Assumes: hit is a single-cycle event from tick_deadline.
module tick_softint #(
    parameter int IRQ_W   = 16,
    parameter int IRQ_BIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             gate_off,
    input  logic [IRQ_W-1:0] clr,
    output logic [IRQ_W-1:0] softint,
    output logic             wake
);

    logic fire;

    // A hit only counts while the counter disable flag is clear.
    assign fire = hit && !gate_off;

    // One status flop per bit; only the assigned bit has a set source.
    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        logic set_i;
        assign set_i = (i == IRQ_BIT) ? fire : 1'b0;

        // Status bit: set wins over write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n) softint[i] <= 1'b0;
            else        softint[i] <= set_i || (softint[i] && !clr[i]);
        end
    end

    // Wake request: one cycle per accepted fire.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= fire;
    end

    // R8: wake lasts exactly one cycle.
    a_r8_wake_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R8: wake is always accompanied by the status bit.
    a_r8_wake_status : assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> softint[IRQ_BIT]);

    // R9: a hit under the disable flag raises nothing.
    a_r9_gated : assert property (@(posedge clk) disable iff (!rst_n)
        (hit && gate_off) |=> !wake);

    // R10: a clear without a fire drops the bit.
    a_r10_clear : assert property (@(posedge clk) disable iff (!rst_n)
        (clr[IRQ_BIT] && !(hit && !gate_off)) |=> !softint[IRQ_BIT]);

    // R10: unassigned bits stay zero.
    a_r10_others : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(softint) <= 1);

endmodule

// File: rtl/tick_cmp_timer.sv
// Module: tick_cmp_timer (top)
// Free-running tick counter plus one-shot compare interrupt.
// Bit REG_W-1 of each written word is a disable flag, the rest is data.
// Assumes: strobes are single-cycle levels sampled on the rising edge.
module tick_cmp_timer #(
    parameter int CNT_W   = 63,
    parameter int IRQ_W   = 16,
    parameter int IRQ_BIT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               cnt_wr,
    input  logic               cmp_wr,
    input  logic [CNT_W:0]     wr_data,
    input  logic [IRQ_W-1:0]   softint_clr,
    output logic [CNT_W:0]     cnt_rd_data,
    output logic [IRQ_W-1:0]   softint,
    output logic               wake
);

    localparam int FLAG_POS = CNT_W;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_inc;
    logic             dis_flag;
    logic             step;
    logic             hit;

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load      (cnt_wr),
        .load_val  (wr_data[CNT_W-1:0]),
        .load_dis  (wr_data[FLAG_POS]),
        .count     (count),
        .count_inc (count_inc),
        .dis_flag  (dis_flag),
        .step      (step)
    );

    tick_deadline #(.CNT_W(CNT_W)) u_dl (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_wr    (cmp_wr),
        .arm_val   (wr_data[CNT_W-1:0]),
        .arm_dis   (wr_data[FLAG_POS]),
        .step      (step),
        .count     (count),
        .count_inc (count_inc),
        .hit       (hit)
    );

    tick_softint #(.IRQ_W(IRQ_W), .IRQ_BIT(IRQ_BIT)) u_si (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .gate_off (dis_flag),
        .clr      (softint_clr),
        .softint  (softint),
        .wake     (wake)
    );

    // Read word: flag on top, live count below.
    assign cnt_rd_data = {dis_flag, count};

    // R3: the read flag follows the last counter write.
    a_r3_read_flag : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_rd_data[FLAG_POS] == $past(wr_data[FLAG_POS])));

    // R1: first cycle after reset shows the disable flag set.
    a_r1_reset_flag : assert property (@(posedge clk)
        !rst_n |=> cnt_rd_data[FLAG_POS]);

endmodule

// File: tb/tick_cmp_timer_tb.sv
module tick_cmp_timer_tb;

    localparam int IRQ_W = 16;
    localparam logic [15:0] SI = 16'h0004;   // IRQ_BIT = 2

    typedef struct packed {
        logic [2:0]  op;      // {cmp_wr, cnt_wr, tick_en}
        logic [63:0] data;
        logic [15:0] clr;
        logic [63:0] exp_rd;
        logic [15:0] exp_si;
        logic        exp_wk;
    } vec_t;

    localparam int NV = 40;
    localparam logic [63:0] D = 64'h8000_0000_0000_0000;

    localparam vec_t VEC [NV] = '{
        '{3'b001, 64'h0,        16'h0,    D | 64'h1,   16'h0, 1'b0}, // 0  R2 counts while flagged
        '{3'b010, 64'h10,       16'h0,    64'h10,      16'h0, 1'b0}, // 1  R2 load
        '{3'b100, 64'h14,       16'h0,    64'h10,      16'h0, 1'b0}, // 2  R4 arm
        '{3'b001, 64'h0,        16'h0,    64'h11,      16'h0, 1'b0}, // 3
        '{3'b001, 64'h0,        16'h0,    64'h12,      16'h0, 1'b0}, // 4
        '{3'b001, 64'h0,        16'h0,    64'h13,      16'h0, 1'b0}, // 5
        '{3'b001, 64'h0,        16'h0,    64'h14,      SI,    1'b1}, // 6  R4 R8 fire
        '{3'b001, 64'h0,        16'h0,    64'h15,      SI,    1'b0}, // 7  R5 R8 no refire
        '{3'b000, 64'h0,        16'h4,    64'h15,      16'h0, 1'b0}, // 8  R10 clear
        '{3'b100, 64'h5,        16'h0,    64'h15,      16'h0, 1'b0}, // 9  R4 past deadline
        '{3'b000, 64'h0,        16'h0,    64'h15,      16'h0, 1'b0}, // 10 no tick no fire
        '{3'b001, 64'h0,        16'h0,    64'h16,      SI,    1'b1}, // 11 R4 fires next tick
        '{3'b100, 64'h3,        16'h0,    64'h16,      SI,    1'b0}, // 12
        '{3'b001, 64'h0,        16'h4,    64'h17,      SI,    1'b1}, // 13 R10 set wins
        '{3'b000, 64'h0,        16'h4,    64'h17,      16'h0, 1'b0}, // 14
        '{3'b100, D | 64'h1,    16'h0,    64'h17,      16'h0, 1'b0}, // 15 R7 disabled write
        '{3'b001, 64'h0,        16'h0,    64'h18,      16'h0, 1'b0}, // 16 R7 no fire
        '{3'b100, 64'h1,        16'h0,    64'h18,      16'h0, 1'b0}, // 17
        '{3'b100, 64'h0,        16'h0,    64'h18,      16'h0, 1'b0}, // 18 R6 zero cancels
        '{3'b001, 64'h0,        16'h0,    64'h19,      16'h0, 1'b0}, // 19 R6 no fire
        '{3'b100, 64'h30,       16'h0,    64'h19,      16'h0, 1'b0}, // 20
        '{3'b010, D | 64'h2F,   16'h0,    D | 64'h2F,  16'h0, 1'b0}, // 21 R3 flag read
        '{3'b001, 64'h0,        16'h0,    D | 64'h30,  16'h0, 1'b0}, // 22 R9 gated
        '{3'b010, 64'h2F,       16'h0,    64'h2F,      16'h0, 1'b0}, // 23
        '{3'b001, 64'h0,        16'h0,    64'h30,      16'h0, 1'b0}, // 24 R9 deadline used
        '{3'b010, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0, 1'b0}, // 25
        '{3'b001, 64'h0,        16'h0,    64'h0,       16'h0, 1'b0}, // 26 R2 wrap
        '{3'b011, 64'h40,       16'h0,    64'h40,      16'h0, 1'b0}, // 27 R11 load beats tick
        '{3'b100, 64'h42,       16'h0,    64'h40,      16'h0, 1'b0}, // 28
        '{3'b001, 64'h0,        16'h0,    64'h41,      16'h0, 1'b0}, // 29
        '{3'b101, 64'h41,       16'h0,    64'h42,      16'h0, 1'b0}, // 30 R11 write blocks fire
        '{3'b001, 64'h0,        16'h0,    64'h43,      SI,    1'b1}, // 31 R11 new deadline
        '{3'b000, 64'h0,        16'hFFFF, 64'h43,      16'h0, 1'b0}, // 32 R10
        '{3'b100, 64'h1,        16'h0,    64'h43,      16'h0, 1'b0}, // 33
        '{3'b100, D | 64'h1,    16'h0,    64'h43,      16'h0, 1'b0}, // 34 R7 cancels
        '{3'b001, 64'h0,        16'h0,    64'h44,      16'h0, 1'b0}, // 35
        '{3'b100, 64'h1,        16'h0,    64'h44,      16'h0, 1'b0}, // 36
        '{3'b001, 64'h0,        16'h0,    64'h45,      SI,    1'b1}, // 37
        '{3'b000, 64'h0,        16'hFFFB, 64'h45,      SI,    1'b0}, // 38 R10 other bits
        '{3'b000, 64'h0,        16'h4,    64'h45,      16'h0, 1'b0}  // 39
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tick_en, cnt_wr, cmp_wr;
    logic [63:0]       wr_data;
    logic [IRQ_W-1:0]  softint_clr;
    logic [63:0]       cnt_rd_data;
    logic [IRQ_W-1:0]  softint;
    logic              wake;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tick_cmp_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cnt_wr      (cnt_wr),
        .cmp_wr      (cmp_wr),
        .wr_data     (wr_data),
        .softint_clr (softint_clr),
        .cnt_rd_data (cnt_rd_data),
        .softint     (softint),
        .wake        (wake)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [63:0] d, input logic [15:0] c);
        tick_en     = op[0];
        cnt_wr      = op[1];
        cmp_wr      = op[2];
        wr_data     = d;
        softint_clr = c;
        @(negedge clk);
        tick_en = 1'b0; cnt_wr = 1'b0; cmp_wr = 1'b0; wr_data = '0; softint_clr = '0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        tick_en = 1'b0; cnt_wr = 1'b0; cmp_wr = 1'b0; wr_data = '0; softint_clr = '0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 rd", cnt_rd_data, D);
        chk("R1 softint", {48'h0, softint}, 64'h0);
        chk("R1 wake", {63'h0, wake}, 64'h0);
        rst_n = 1'b1;

        // Vector table walk (R2..R11)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].data, VEC[i].clr);
            chk($sformatf("v%0d rd R3", i), cnt_rd_data, VEC[i].exp_rd);
            chk($sformatf("v%0d softint R8", i), {48'h0, softint}, {48'h0, VEC[i].exp_si});
            chk($sformatf("v%0d wake R8", i), {63'h0, wake}, {63'h0, VEC[i].exp_wk});
        end

        // R1: reset mid-run clears status and cancels an armed deadline
        drive(3'b100, 64'h1, 16'h0);
        drive(3'b001, 64'h0, 16'h0);
        chk("R1 pre-reset status", {48'h0, softint}, {48'h0, SI});
        drive(3'b100, 64'h47, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rd after reset", cnt_rd_data, D);
        chk("R1 softint after reset", {48'h0, softint}, 64'h0);
        drive(3'b010, 64'h46, 16'h0);
        drive(3'b001, 64'h0, 16'h0);
        chk("R1 no armed deadline rd", cnt_rd_data, 64'h47);
        chk("R1 no armed deadline wake", {63'h0, wake}, 64'h0);
        drive(3'b001, 64'h0, 16'h0);
        chk("R1 still unarmed", {48'h0, softint}, 64'h0);

        // R4: deadline exactly one tick ahead fires on that tick
        drive(3'b100, 64'h49, 16'h0);
        drive(3'b001, 64'h0, 16'h0);
        chk("R4 exact match wake", {63'h0, wake}, 64'h1);
        chk("R4 exact match rd", cnt_rd_data, 64'h49);

        finish_run();
    end

endmodule